// File: doc/BRIEF.md
# Two-Wire Target Front End for a Multichannel Converter

This block sits between a two-wire (I2C) bus and the conversion controller of an eight-channel data-acquisition converter. It watches the bus for START and STOP, recognises its own 7-bit address, and then takes one of two paths. A write carries a control word that picks the channel, the input span, the polarity and the low-power mode. A read returns the latest conversion result as two bytes.

Both bus lines are resampled in the system clock domain, and every bus decision is made from the synchronised samples. SDA is driven as an open-drain pull-down enable. The controller gets the decoded control fields, plus single-cycle strobes for a matching address, for the polarity bit of the control word, for a complete control word and for STOP. It supplies the conversion result in return.

Top module: `daq_i2c_target`

## Requirements
- R1: After reset the SDA pull-down is off, every control field output is 0, and no strobe is active.
- R2: The target answers only to the address whose upper four bits are 0101 and whose lower three bits equal strap_i[2:0]. On a match it pulls SDA low through the ninth clock. On any other address it leaves SDA released and ignores the bus until the next START.
- R3: A matching address raises addr_hit_o for one cycle. addr_rw_o then holds the received R/W bit: 0 for a write, 1 for a read.
- R4: On a write, the target skips 0 bits after the address acknowledge. The first 1 is the marker bit (bit 7) of the control byte, and the byte runs MSB first from there. Its fields are channel in bits 6..4, range in bit 3, bipolar in bit 2 and power-down in bits 1..0. The byte is acknowledged on its ninth clock. The field outputs change only when a complete byte has arrived, and ctrl_valid_o pulses at that moment.
- R5: acq_start_o pulses exactly once per control byte, at the clock that carries bit 2.
- R6: On a read, the result on result_i is captured when the address matches. It is sent left-justified, MSB first: bits 11..4 in the first byte, then bits 3..0 followed by four zeros.
- R7: The master's ACK and NACK after each read byte have no effect. The target keeps clocking out data, and the byte after the second is the first byte again.
- R8: The SDA pull-down changes state only while SCL is low.
- R9: A START at any point, even in the middle of a byte, restarts address reception. A STOP releases SDA, returns the target to idle and pulses stop_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 3 | Pin-strapped low address bits |
| result_i | input | RES_W (12) | Conversion result from the controller |
| chan_o | output | 3 | Selected channel |
| range_o | output | 1 | Range select bit |
| bipolar_o | output | 1 | Polarity select bit |
| pdown_o | output | 2 | Power-down mode field |
| addr_hit_o | output | 1 | Strobe: own address received |
| addr_rw_o | output | 1 | R/W bit of the last matching address |
| acq_start_o | output | 1 | Strobe: control bit 2 received |
| ctrl_valid_o | output | 1 | Strobe: control byte latched |
| stop_o | output | 1 | Strobe: STOP seen |

## Verification
The bench sends a control byte behind three leading zeros. A target that treated the first bit as the marker would latch a shifted word and acknowledge at the wrong clock. It sends a foreign address followed by an all-ones byte. A target that wrongly went on listening would take that byte as a control word and change its fields. On reads it changes result_i after the address and answers NACK mid-transfer. A target that sampled late, or that honoured the NACK, would send the wrong bytes or fail to wrap to the first byte. A START in the middle of an address byte must resynchronise the bit counter, and a monitor flags any SDA pull-down change while SCL is high.

// File: rtl/daq_i2c_pkg.sv
package daq_i2c_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ACK,
      ST_HUNT,
      ST_CTRL,
      ST_TX,
      ST_MACK
   } twi_state_e;

   // Control byte without its marker bit, in bit order 6..0.
   typedef struct packed {
      logic [2:0] chan;
      logic       range;
      logic       bipolar;
      logic [1:0] pdown;
   } ctrl_word_t;

   localparam int BYTE_BITS = 8;
   localparam int TX_BITS   = 16;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("twi_line_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[0] <= 1'b1;
      else        chain_q[0] <= line_i;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q[i] <= 1'b1;
         else        chain_q[i] <= chain_q[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b1;
      else        last_q <= chain_q[STAGES-1];
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~last_q;
   assign fall_o  = ~chain_q[STAGES-1] & last_q;

endmodule

// File: rtl/twi_cond_detect.sv
module twi_cond_detect (
   input  logic scl_lvl_i,
   input  logic scl_rise_i,
   input  logic sda_rise_i,
   input  logic sda_fall_i,
   output logic start_o,
   output logic stop_o
);

   logic scl_steady_high;

   // Data edges only mark a condition while the clock has been high already.
   assign scl_steady_high = scl_lvl_i & ~scl_rise_i;
   assign start_o         = scl_steady_high & sda_fall_i;
   assign stop_o          = scl_steady_high & sda_rise_i;

endmodule

// File: rtl/twi_target_fsm.sv
module twi_target_fsm
   import daq_i2c_pkg::*;
#(
   parameter int         RES_W   = 12,
   parameter logic [3:0] ADDR_HI = 4'b0101,
   parameter int         BIP_POS = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sda_lvl_i,
   input  logic             scl_rise_i,
   input  logic             scl_fall_i,
   input  logic             start_i,
   input  logic             stop_i,
   input  logic [2:0]       strap_i,
   input  logic [RES_W-1:0] result_i,
   output logic             sda_oe_o,
   output ctrl_word_t       ctrl_o,
   output logic             addr_hit_o,
   output logic             addr_rw_o,
   output logic             acq_start_o,
   output logic             ctrl_valid_o,
   output logic             stop_o
);

   localparam int         PAD_W   = TX_BITS - RES_W;
   localparam logic [3:0] LAST_IX = 4'(BYTE_BITS - 1);
   localparam logic [3:0] BIP_IX  = 4'(BYTE_BITS - 1 - BIP_POS);
   localparam logic [3:0] DONE_IX = 4'(BYTE_BITS);

   if (RES_W <= BYTE_BITS || RES_W > TX_BITS) begin : g_bad_res
      $error("twi_target_fsm: RES_W must be in 9..16");
   end
   if (BIP_POS < 0 || BIP_POS > BYTE_BITS - 2) begin : g_bad_bip
      $error("twi_target_fsm: BIP_POS out of range");
   end

   twi_state_e             state_q;
   logic [3:0]             cnt_q;
   logic [BYTE_BITS-1:0]   sh_q;
   logic                   ack_ph_q;
   logic                   rd_q;
   logic [TX_BITS-1:0]     tx_q;
   logic [TX_BITS-1:0]     tx_load;
   logic                   oe_q;
   ctrl_word_t             ctrl_q;
   logic                   hit_q, rw_q, acq_q, cv_q, stp_q;
   logic [6:0]             own_addr;

   assign own_addr = {ADDR_HI, strap_i};

   // Left-justify the result in the two-byte frame.
   if (PAD_W == 0) begin : g_no_pad
      assign tx_load = result_i;
   end else begin : g_pad
      assign tx_load = {result_i, {PAD_W{1'b0}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         sh_q     <= '0;
         ack_ph_q <= 1'b0;
         rd_q     <= 1'b0;
         tx_q     <= '0;
         oe_q     <= 1'b0;
         ctrl_q   <= '0;
         hit_q    <= 1'b0;
         rw_q     <= 1'b0;
         acq_q    <= 1'b0;
         cv_q     <= 1'b0;
         stp_q    <= 1'b0;
      end else begin
         hit_q <= 1'b0;
         acq_q <= 1'b0;
         cv_q  <= 1'b0;
         stp_q <= 1'b0;
         if (stop_i) begin
            state_q <= ST_IDLE;
            oe_q    <= 1'b0;
            stp_q   <= 1'b1;
         end else if (start_i) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
         end else begin
            unique case (state_q)
               ST_IDLE: ;
               ST_ADDR: begin
                  if (scl_rise_i) begin
                     sh_q  <= {sh_q[BYTE_BITS-2:0], sda_lvl_i};
                     cnt_q <= cnt_q + 4'd1;
                     if (cnt_q == LAST_IX) begin
                        if (sh_q[6:0] == own_addr) begin
                           state_q  <= ST_ACK;
                           ack_ph_q <= 1'b0;
                           rd_q     <= sda_lvl_i;
                           rw_q     <= sda_lvl_i;
                           hit_q    <= 1'b1;
                           if (sda_lvl_i) tx_q <= tx_load;
                        end else begin
                           state_q <= ST_IDLE;
                        end
                     end
                  end
               end
               ST_ACK: begin
                  if (scl_fall_i) begin
                     if (!ack_ph_q) begin
                        oe_q     <= 1'b1;
                        ack_ph_q <= 1'b1;
                     end else begin
                        ack_ph_q <= 1'b0;
                        if (rd_q) begin
                           state_q <= ST_TX;
                           cnt_q   <= '0;
                           oe_q    <= ~tx_q[TX_BITS-1];
                        end else begin
                           state_q <= ST_HUNT;
                           oe_q    <= 1'b0;
                        end
                     end
                  end
               end
               ST_HUNT: begin
                  if (scl_rise_i && sda_lvl_i) begin
                     state_q <= ST_CTRL;
                     cnt_q   <= 4'd1;
                     sh_q    <= 8'h01;
                  end
               end
               ST_CTRL: begin
                  if (scl_rise_i) begin
                     sh_q  <= {sh_q[BYTE_BITS-2:0], sda_lvl_i};
                     cnt_q <= cnt_q + 4'd1;
                     if (cnt_q == BIP_IX) acq_q <= 1'b1;
                     if (cnt_q == LAST_IX) begin
                        ctrl_q   <= {sh_q[5:0], sda_lvl_i};
                        cv_q     <= 1'b1;
                        state_q  <= ST_ACK;
                        ack_ph_q <= 1'b0;
                        rd_q     <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (scl_rise_i) begin
                     cnt_q <= cnt_q + 4'd1;
                  end else if (scl_fall_i) begin
                     tx_q <= {tx_q[TX_BITS-2:0], tx_q[TX_BITS-1]};
                     if (cnt_q == DONE_IX) begin
                        oe_q    <= 1'b0;
                        state_q <= ST_MACK;
                     end else begin
                        oe_q <= ~tx_q[TX_BITS-2];
                     end
                  end
               end
               ST_MACK: begin
                  // The master's ACK/NACK is not examined.
                  if (scl_fall_i) begin
                     state_q <= ST_TX;
                     cnt_q   <= '0;
                     oe_q    <= ~tx_q[TX_BITS-1];
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign sda_oe_o     = oe_q;
   assign ctrl_o       = ctrl_q;
   assign addr_hit_o   = hit_q;
   assign addr_rw_o    = rw_q;
   assign acq_start_o  = acq_q;
   assign ctrl_valid_o = cv_q;
   assign stop_o       = stp_q;

   // R8: the pull-down only moves after a clock fall (or on a bus condition).
   a_r8_oe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q != $past(oe_q)) |-> $past(scl_fall_i || start_i || stop_i));

   // R2: an idle target never holds the line.
   a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |-> !oe_q);

   // R4: the control fields move only together with the valid strobe.
   a_r4_fields_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q != $past(ctrl_q)) |-> cv_q);

   // R9: a STOP leaves the target idle with SDA released.
   a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |=> (!oe_q && state_q == ST_IDLE && stp_q));

   // R5: event strobes never overlap.
   a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit_q, acq_q, cv_q, stp_q}));

   // R9: START and STOP are never reported together.
   a_r9_cond_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_i && stop_i));

endmodule

// File: rtl/daq_i2c_target.sv
module daq_i2c_target
   import daq_i2c_pkg::*;
#(
   parameter int         RES_W       = 12,
   parameter int         SYNC_STAGES = 2,
   parameter logic [3:0] ADDR_HI     = 4'b0101
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe_o,
   input  logic [2:0]       strap_i,
   input  logic [RES_W-1:0] result_i,
   output logic [2:0]       chan_o,
   output logic             range_o,
   output logic             bipolar_o,
   output logic [1:0]       pdown_o,
   output logic             addr_hit_o,
   output logic             addr_rw_o,
   output logic             acq_start_o,
   output logic             ctrl_valid_o,
   output logic             stop_o
);

   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;
   logic cond_start, cond_stop;
   ctrl_word_t ctrl;

   twi_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (scl_i),
      .level_o(scl_lvl),
      .rise_o (scl_rise),
      .fall_o (scl_fall)
   );

   twi_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (sda_i),
      .level_o(sda_lvl),
      .rise_o (sda_rise),
      .fall_o (sda_fall)
   );

   twi_cond_detect u_cond (
      .scl_lvl_i (scl_lvl),
      .scl_rise_i(scl_rise),
      .sda_rise_i(sda_rise),
      .sda_fall_i(sda_fall),
      .start_o   (cond_start),
      .stop_o    (cond_stop)
   );

   twi_target_fsm #(
      .RES_W  (RES_W),
      .ADDR_HI(ADDR_HI),
      .BIP_POS(2)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sda_lvl_i   (sda_lvl),
      .scl_rise_i  (scl_rise),
      .scl_fall_i  (scl_fall),
      .start_i     (cond_start),
      .stop_i      (cond_stop),
      .strap_i     (strap_i),
      .result_i    (result_i),
      .sda_oe_o    (sda_oe_o),
      .ctrl_o      (ctrl),
      .addr_hit_o  (addr_hit_o),
      .addr_rw_o   (addr_rw_o),
      .acq_start_o (acq_start_o),
      .ctrl_valid_o(ctrl_valid_o),
      .stop_o      (stop_o)
   );

   assign chan_o    = ctrl.chan;
   assign range_o   = ctrl.range;
   assign bipolar_o = ctrl.bipolar;
   assign pdown_o   = ctrl.pdown;

endmodule

// File: tb/daq_i2c_target_bench.sv
module daq_i2c_target_bench;

   localparam int QTR = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic        sda_line;
   logic        sda_oe;
   logic [2:0]  strap = 3'b101;
   logic [11:0] result = '0;
   logic [2:0]  chan;
   logic        range_b, bip, rw;
   logic [1:0]  pdown;
   logic        hit, acq, cvalid, stp;

   int n_chk = 0, n_err = 0;
   int n_hit = 0, n_acq = 0, n_ctl = 0, n_stop = 0, bad_edge = 0;
   logic oe_prev = 1'b0;
   logic timed_out = 1'b0;

   always #10 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   daq_i2c_target u_daq_i2c_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .strap_i(strap), .result_i(result),
      .chan_o(chan), .range_o(range_b), .bipolar_o(bip), .pdown_o(pdown),
      .addr_hit_o(hit), .addr_rw_o(rw), .acq_start_o(acq),
      .ctrl_valid_o(cvalid), .stop_o(stp)
   );

   always @(posedge clk) begin
      if (rst_n) begin
         if (hit)    n_hit++;
         if (acq)    n_acq++;
         if (cvalid) n_ctl++;
         if (stp)    n_stop++;
         if (sda_oe !== oe_prev && scl_m) bad_edge++;
      end
      oe_prev <= sda_oe;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic qwait();
      repeat (QTR) @(negedge clk);
   endtask

   task automatic m_start();
      sda_m = 1'b1; qwait();
      scl_m = 1'b1; qwait();
      sda_m = 1'b0; qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic m_stop();
      sda_m = 1'b0; qwait();
      scl_m = 1'b1; qwait();
      sda_m = 1'b1; qwait(); qwait();
   endtask

   task automatic m_bit(input logic b, output logic r);
      sda_m = b; qwait();
      scl_m = 1'b1; qwait();
      r = sda_line; qwait();
      scl_m = 1'b0; qwait();
   endtask

   task automatic m_wbyte(input logic [7:0] d, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) m_bit(d[i], r);
      m_bit(1'b1, r);
      ack = ~r;
   endtask

   task automatic m_rbyte(input logic mack, output logic [7:0] d);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         m_bit(1'b1, r);
         d[i] = r;
      end
      m_bit(~mack, r);
   endtask

   task automatic t_reset();
      check(sda_oe == 1'b0, "R1 oe", sda_oe, 0);
      check({chan, range_b, bip, pdown} == 7'd0, "R1 fields", {chan, range_b, bip, pdown}, 0);
      check(n_hit + n_acq + n_ctl + n_stop == 0, "R1 strobes", n_hit + n_acq + n_ctl + n_stop, 0);
   endtask

   task automatic t_write_basic();
      logic a;
      int h = n_hit, q = n_acq, c = n_ctl, s = n_stop;
      m_start();
      m_wbyte({4'b0101, 3'b101, 1'b0}, a);
      check(a, "R2 addr ack", a, 1);
      check(rw == 1'b0, "R3 rw write", rw, 0);
      m_wbyte(8'b1_011_1_0_10, a);
      check(a, "R4 ctrl ack", a, 1);
      m_stop();
      check({chan, range_b, bip, pdown} == 7'b011_1_0_10, "R4 fields", {chan, range_b, bip, pdown}, 7'b0111010);
      check(n_hit - h == 1, "R3 hit strobe", n_hit - h, 1);
      check(n_acq - q == 1, "R5 acq strobe", n_acq - q, 1);
      check(n_ctl - c == 1, "R4 valid strobe", n_ctl - c, 1);
      check(n_stop - s == 1, "R9 stop strobe", n_stop - s, 1);
   endtask

   task automatic t_marker_hunt();
      logic a, r;
      int q = n_acq;
      m_start();
      m_wbyte({4'b0101, 3'b101, 1'b0}, a);
      for (int i = 0; i < 3; i++) m_bit(1'b0, r);
      check(sda_oe == 1'b0, "R4 no early ack", sda_oe, 0);
      m_wbyte(8'b1_110_0_1_01, a);
      check(a, "R4 ack after marker byte", a, 1);
      m_stop();
      check({chan, range_b, bip, pdown} == 7'b110_0_1_01, "R4 hunted fields", {chan, range_b, bip, pdown}, 7'b1100101);
      check(n_acq - q == 1, "R5 one acq per byte", n_acq - q, 1);
   endtask

   task automatic t_mismatch();
      logic a;
      int h = n_hit, c = n_ctl;
      m_start();
      m_wbyte({4'b0101, 3'b100, 1'b0}, a);
      check(!a, "R2 no ack on foreign address", a, 0);
      m_wbyte(8'hFF, a);
      check(!a, "R2 ignored byte not acked", a, 0);
      m_stop();
      check({chan, range_b, bip, pdown} == 7'b110_0_1_01, "R2 fields untouched", {chan, range_b, bip, pdown}, 7'b1100101);
      check(n_hit == h && n_ctl == c, "R2 no strobes", n_hit - h + n_ctl - c, 0);
   endtask

   task automatic t_read_wrap();
      logic a;
      logic [7:0] d;
      result = 12'hA5C;
      m_start();
      m_wbyte({4'b0101, 3'b101, 1'b1}, a);
      check(a, "R2 read addr ack", a, 1);
      check(rw == 1'b1, "R3 rw read", rw, 1);
      result = 12'h123;
      m_rbyte(1'b1, d);
      check(d == 8'hA5, "R6 first byte", d, 8'hA5);
      m_rbyte(1'b0, d);
      check(d == 8'hC0, "R6 second byte", d, 8'hC0);
      m_rbyte(1'b0, d);
      check(d == 8'hA5, "R7 wrap after nack", d, 8'hA5);
      m_stop();
   endtask

   task automatic t_read_nack_early();
      logic a;
      logic [7:0] d;
      result = 12'hC81;
      m_start();
      m_wbyte({4'b0101, 3'b101, 1'b1}, a);
      m_rbyte(1'b0, d);
      check(d == 8'hC8, "R6 byte one", d, 8'hC8);
      m_rbyte(1'b0, d);
      check(d == 8'h10, "R7 byte two despite nack", d, 8'h10);
      m_stop();
   endtask

   task automatic t_restart_mid();
      logic a, r;
      int s = n_stop;
      m_start();
      m_bit(1'b0, r); m_bit(1'b1, r); m_bit(1'b0, r); m_bit(1'b1, r);
      m_start();
      m_wbyte({4'b0101, 3'b101, 1'b0}, a);
      check(a, "R9 ack after restart", a, 1);
      m_wbyte(8'b1_001_1_1_11, a);
      m_stop();
      check({chan, range_b, bip, pdown} == 7'b001_1_1_11, "R9 fields after restart", {chan, range_b, bip, pdown}, 7'b0011111);
      check(n_stop - s == 1, "R9 stop counted", n_stop - s, 1);
      check(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
   endtask

   task automatic run_all();
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_write_basic();
      t_marker_hunt();
      t_mismatch();
      t_read_wrap();
      t_read_nack_early();
      t_restart_mid();
      check(bad_edge == 0, "R8 oe moved with scl high", bad_edge, 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=1 expected=0");
      end
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule